// File: doc/BRIEF.md
# UART Modem Loop-Back Path

This block sits between a UART's serial engines, its modem-control register and the package pins. In normal operation it passes the transmitter's serial output to the TX pin and the RX pin to the receiver. It drives the four modem-control outputs from their register bits. It synchronizes the four external modem inputs and keeps the modem status register.

When the diagnostic loop-back bit is set, the block cuts both serial pins off from the core. The transmitter's output is fed straight into the receiver's line. The modem inputs seen by the status logic are then taken from the four control bits instead of from the pins. Software can exercise the transmit path, the receive path and the modem-status interrupt path without any external wiring.

The status register holds the current modem levels and four sticky change flags. The host clears the flags by reading the register. A modem-status interrupt request is raised while any flag is set and the interrupt is enabled. Loop-back does not change this behaviour: the change flags in the low nibble still carry the interrupt indication.

Top module: `uart_modem_loop`

## Requirements
- R1: `rx_line_o` equals `tx_serial_i` while `loop_en_i` is 1 and equals `rx_pin_i` while it is 0, with no register on the path.
- R2: `tx_pin_o` is held at the idle mark level 1 while `loop_en_i` is 1 and follows `tx_serial_i` while it is 0. In loop-back, `rx_pin_i` has no effect on any output.
- R3: `dtr_pin_o`, `rts_pin_o`, `out1_pin_o` and `out2_pin_o` follow `dtr_ctl_i`, `rts_ctl_i`, `out1_ctl_i` and `out2_ctl_i` while loop-back is off. They are driven inactive (0) while it is on.
- R4: With loop-back off, each external modem input passes through a two-flop synchronizer and then the level register. A pin change shows in `msr_o` after the third rising edge. The level bits are: bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD.
- R5: With loop-back on, the effective levels come from the control bits: CTS from DTR, DSR from RTS, RI from OUT1, DCD from OUT2. They appear in `msr_o[7:4]` after one rising edge, and the external modem pins are ignored.
- R6: `msr_o[0]` (CTS), `msr_o[1]` (DSR) and `msr_o[3]` (DCD) are set in the same edge at which the matching level bit changes in either direction.
- R7: `msr_o[2]` is set only when the RI level bit goes from 1 to 0. A rise of RI does not set it.
- R8: Change flags are sticky. A clock edge with `msr_rd_i` high clears them, but a change captured in that same edge still sets its flag.
- R9: `msi_req_o` is 1 exactly when `msi_en_i` is 1 and at least one of `msr_o[3:0]` is 1. This holds in both modes.
- R10: While `rst_n` is low, `msr_o` is 0 and `msi_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en_i | input | 1 | Diagnostic loop-back enable |
| tx_serial_i | input | 1 | Serial output of the transmitter |
| rx_pin_i | input | 1 | External receive pin |
| cts_pin_i | input | 1 | External CTS input, active high |
| dsr_pin_i | input | 1 | External DSR input, active high |
| ri_pin_i | input | 1 | External RI input, active high |
| dcd_pin_i | input | 1 | External DCD input, active high |
| dtr_ctl_i | input | 1 | Modem-control bit 0 (DTR) |
| rts_ctl_i | input | 1 | Modem-control bit 1 (RTS) |
| out1_ctl_i | input | 1 | Modem-control bit 2 (OUT1) |
| out2_ctl_i | input | 1 | Modem-control bit 3 (OUT2) |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| msr_rd_i | input | 1 | Host read strobe of the status register |
| rx_line_o | output | 1 | Serial line delivered to the receiver |
| tx_pin_o | output | 1 | Transmit pin |
| dtr_pin_o | output | 1 | DTR output pin, active high |
| rts_pin_o | output | 1 | RTS output pin, active high |
| out1_pin_o | output | 1 | OUT1 output pin, active high |
| out2_pin_o | output | 1 | OUT2 output pin, active high |
| msr_o | output | 8 | Status register: change flags [3:0], levels [7:4] |
| msi_req_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions check the following on every cycle:
- the mark level on the TX pin and the quiet output pins during loop-back;
- the capture of control bits into the level nibble one edge later;
- that a level change always leaves its change flag set;
- that flags never drop without a read;
- that RI falls always set flag 2;
- the interrupt equation.

Only the bench scenarios can show:
- the exact three-edge latency through the synchronizer;
- that an RI rise leaves flag 2 clear;
- that a read coinciding with a change keeps the new flag while clearing the rest;
- that the external pins have no effect while loop-back is on.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    localparam int MODEM_W  = 4;
    localparam int IDX_CTS  = 0;
    localparam int IDX_DSR  = 1;
    localparam int IDX_RI   = 2;
    localparam int IDX_DCD  = 3;
    localparam int STATUS_W = 2 * MODEM_W;

    typedef logic [MODEM_W-1:0] modem_vec_t;

    typedef struct packed {
        modem_vec_t lvl;
        modem_vec_t dlt;
    } status_state_t;
endpackage

// File: rtl/uart_lb_sync.sv
module uart_lb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_lb_route.sv
module uart_lb_route
    import uart_lb_pkg::*;
(
    input  logic       loop_en_i,
    input  logic       tx_serial_i,
    input  logic       rx_pin_i,
    input  modem_vec_t ext_sync_i,
    input  modem_vec_t ctl_i,
    output logic       rx_line_o,
    output logic       tx_pin_o,
    output modem_vec_t pin_out_o,
    output modem_vec_t eff_o
);
    // ctl_i order: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2
    modem_vec_t looped;

    always_comb begin
        looped          = '0;
        looped[IDX_CTS] = ctl_i[0];
        looped[IDX_DSR] = ctl_i[1];
        looped[IDX_RI]  = ctl_i[2];
        looped[IDX_DCD] = ctl_i[3];

        if (loop_en_i) begin
            rx_line_o = tx_serial_i;
            tx_pin_o  = 1'b1;
            pin_out_o = '0;
            eff_o     = looped;
        end else begin
            rx_line_o = rx_pin_i;
            tx_pin_o  = tx_serial_i;
            pin_out_o = ctl_i;
            eff_o     = ext_sync_i;
        end
    end
endmodule

// File: rtl/uart_lb_status.sv
module uart_lb_status
    import uart_lb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  modem_vec_t          eff_i,
    input  logic                rd_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                any_dlt_o
);
    status_state_t st_d, st_q;
    modem_vec_t    events;

    always_comb begin
        events          = eff_i ^ st_q.lvl;
        events[IDX_RI]  = st_q.lvl[IDX_RI] & ~eff_i[IDX_RI];
        st_d.lvl        = eff_i;
        st_d.dlt        = (rd_i ? '0 : st_q.dlt) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = st_q;
    assign any_dlt_o = |st_q.dlt;
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
    import uart_lb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_en_i,
    input  logic       tx_serial_i,
    input  logic       rx_pin_i,
    input  logic       cts_pin_i,
    input  logic       dsr_pin_i,
    input  logic       ri_pin_i,
    input  logic       dcd_pin_i,
    input  logic       dtr_ctl_i,
    input  logic       rts_ctl_i,
    input  logic       out1_ctl_i,
    input  logic       out2_ctl_i,
    input  logic       msi_en_i,
    input  logic       msr_rd_i,
    output logic       rx_line_o,
    output logic       tx_pin_o,
    output logic       dtr_pin_o,
    output logic       rts_pin_o,
    output logic       out1_pin_o,
    output logic       out2_pin_o,
    output logic [7:0] msr_o,
    output logic       msi_req_o
);
    modem_vec_t ext_raw, ext_sync, ctl, pins, eff;
    logic       any_dlt;

    always_comb begin
        ext_raw          = '0;
        ext_raw[IDX_CTS] = cts_pin_i;
        ext_raw[IDX_DSR] = dsr_pin_i;
        ext_raw[IDX_RI]  = ri_pin_i;
        ext_raw[IDX_DCD] = dcd_pin_i;
    end

    assign ctl = {out2_ctl_i, out1_ctl_i, rts_ctl_i, dtr_ctl_i};

    uart_lb_sync #(.WIDTH(MODEM_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_raw),
        .sync_o  (ext_sync)
    );

    uart_lb_route u_route (
        .loop_en_i   (loop_en_i),
        .tx_serial_i (tx_serial_i),
        .rx_pin_i    (rx_pin_i),
        .ext_sync_i  (ext_sync),
        .ctl_i       (ctl),
        .rx_line_o   (rx_line_o),
        .tx_pin_o    (tx_pin_o),
        .pin_out_o   (pins),
        .eff_o       (eff)
    );

    uart_lb_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_i     (eff),
        .rd_i      (msr_rd_i),
        .status_o  (msr_o),
        .any_dlt_o (any_dlt)
    );

    assign dtr_pin_o  = pins[0];
    assign rts_pin_o  = pins[1];
    assign out1_pin_o = pins[2];
    assign out2_pin_o = pins[3];
    assign msi_req_o  = msi_en_i & any_dlt;
endmodule

// File: rtl/uart_modem_loop_chk.sv
module uart_modem_loop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en_i,
    input logic       dtr_ctl_i,
    input logic       rts_ctl_i,
    input logic       out1_ctl_i,
    input logic       out2_ctl_i,
    input logic       msi_en_i,
    input logic       msr_rd_i,
    input logic       tx_pin_o,
    input logic       dtr_pin_o,
    input logic       rts_pin_o,
    input logic       out1_pin_o,
    input logic       out2_pin_o,
    input logic [7:0] msr_o,
    input logic       msi_req_o
);
    assert_tx_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en_i |-> tx_pin_o);

    assert_pins_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en_i |-> !(dtr_pin_o | rts_pin_o | out1_pin_o | out2_pin_o));

    assert_loop_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en_i |=> msr_o[7:4] == {$past(out2_ctl_i), $past(out1_ctl_i),
                                     $past(rts_ctl_i), $past(dtr_ctl_i)});

    assert_change_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((msr_o[7:4] ^ $past(msr_o[7:4])) & 4'b1011) & ~msr_o[3:0]) == 4'b0000);

    assert_ri_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msr_o[6]) |-> msr_o[2]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd_i |=> (msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0]));

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o == (msi_en_i && (msr_o[3:0] != 4'b0000)));
endmodule

bind uart_modem_loop uart_modem_loop_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en_i  (loop_en_i),
    .dtr_ctl_i  (dtr_ctl_i),
    .rts_ctl_i  (rts_ctl_i),
    .out1_ctl_i (out1_ctl_i),
    .out2_ctl_i (out2_ctl_i),
    .msi_en_i   (msi_en_i),
    .msr_rd_i   (msr_rd_i),
    .tx_pin_o   (tx_pin_o),
    .dtr_pin_o  (dtr_pin_o),
    .rts_pin_o  (rts_pin_o),
    .out1_pin_o (out1_pin_o),
    .out2_pin_o (out2_pin_o),
    .msr_o      (msr_o),
    .msi_req_o  (msi_req_o)
);

// File: tb/uart_modem_loop_test.sv
`timescale 1ns/1ps
module uart_modem_loop_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, loop_en, tx_ser, rx_pin, msi_en, rd;
    logic [3:0] ext;   // [0] CTS, [1] DSR, [2] RI, [3] DCD
    logic [3:0] ctl;   // [0] DTR, [1] RTS, [2] OUT1, [3] OUT2
    logic rx_line, tx_pin, dtr_p, rts_p, o1_p, o2_p, irq;
    logic [7:0] msr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    uart_modem_loop uut (
        .clk(clk), .rst_n(rst_n), .loop_en_i(loop_en), .tx_serial_i(tx_ser),
        .rx_pin_i(rx_pin), .cts_pin_i(ext[0]), .dsr_pin_i(ext[1]),
        .ri_pin_i(ext[2]), .dcd_pin_i(ext[3]), .dtr_ctl_i(ctl[0]),
        .rts_ctl_i(ctl[1]), .out1_ctl_i(ctl[2]), .out2_ctl_i(ctl[3]),
        .msi_en_i(msi_en), .msr_rd_i(rd), .rx_line_o(rx_line),
        .tx_pin_o(tx_pin), .dtr_pin_o(dtr_p), .rts_pin_o(rts_p),
        .out1_pin_o(o1_p), .out2_pin_o(o2_p), .msr_o(msr), .msi_req_o(irq)
    );

    // reference model built from the requirements
    logic [3:0] m_s1, m_s2, m_lvl, m_dlt;

    function automatic logic [3:0] f_eff(logic lp, logic [3:0] c, logic [3:0] e);
        return lp ? c : e;   // R5 map: CTS<-DTR, DSR<-RTS, RI<-OUT1, DCD<-OUT2
    endfunction

    function automatic logic [3:0] f_ev(logic [3:0] old_l, logic [3:0] new_l);
        logic [3:0] ev;
        ev    = old_l ^ new_l;
        ev[2] = old_l[2] & ~new_l[2];
        return ev;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_dlt <= '0;
        end else begin
            m_s1  <= ext;
            m_s2  <= m_s1;
            m_lvl <= f_eff(loop_en, ctl, m_s2);
            m_dlt <= (rd ? 4'b0 : m_dlt) | f_ev(m_lvl, f_eff(loop_en, ctl, m_s2));
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_comb();
        chk("R1", {7'b0, rx_line}, {7'b0, loop_en ? tx_ser : rx_pin});
        chk("R2", {7'b0, tx_pin}, {7'b0, loop_en ? 1'b1 : tx_ser});
        chk("R3", {4'b0, o2_p, o1_p, rts_p, dtr_p}, {4'b0, loop_en ? 4'b0 : ctl});
        chk("R9", {7'b0, irq}, {7'b0, msi_en && (m_dlt != 0)});
    endtask

    task automatic check_regs();
        chk(loop_en ? "R5" : "R4", {4'b0, msr[7:4]}, {4'b0, m_lvl});
        chk("R6", {5'b0, msr[3], msr[1:0]}, {5'b0, m_dlt[3], m_dlt[1:0]});
        chk("R7", {7'b0, msr[2]}, {7'b0, m_dlt[2]});
    endtask

    task automatic tick();
        #1 check_comb();
        @(posedge clk);
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2027));
        rst_n = 0; loop_en = 0; tx_ser = 1; rx_pin = 1; msi_en = 1; rd = 0;
        ext = 4'hF; ctl = 4'h0;
        repeat (3) @(negedge clk);
        chk("R10", msr, 8'h00);
        chk("R10", {7'b0, irq}, 8'h00);
        rst_n = 1;

        // R4 latency: pins high since reset, levels land after third edge
        @(posedge clk); @(negedge clk);
        chk("R4", {4'b0, msr[7:4]}, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R4", {4'b0, msr[7:4]}, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R4", {4'b0, msr[7:4]}, 8'h0F);
        rd = 1; tick(); rd = 0; tick();

        // R7: RI rise in loop-back does not flag, RI fall does
        loop_en = 1; ctl = 4'b0000; tick(); tick();
        rd = 1; tick(); rd = 0;
        ctl[2] = 1; tick();
        chk("R7", {7'b0, msr[2]}, 8'h00);
        ctl[2] = 0; tick();
        chk("R7", {7'b0, msr[2]}, 8'h01);

        // R8: read clears, but change in the read cycle still flags
        rd = 1; tick();
        chk("R8", {4'b0, msr[3:0]}, 8'h00);
        ctl[0] = 1; rd = 1; tick();
        chk("R8", {4'b0, msr[3:0]}, 8'h01);
        rd = 1; tick(); rd = 0;
        chk("R8", {4'b0, msr[3:0]}, 8'h00);

        // R5: external pins ignored in loop-back
        ext = ~ext; rx_pin = 0; tick(); tick(); tick(); tick();
        chk("R5", msr, 8'h10);
        chk("R2", {7'b0, tx_pin}, 8'h01);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(31) == 0) loop_en = ~loop_en;
            tx_ser = 1'($urandom);
            rx_pin = 1'($urandom);
            if ($urandom_range(3) == 0) ext = 4'($urandom);
            if ($urandom_range(3) == 0) ctl = 4'($urandom);
            if ($urandom_range(15) == 0) msi_en = ~msi_en;
            rd = ($urandom_range(3) == 0);
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule